// File: doc/BRIEF.md
# Pre-Framed Asynchronous Serial Transmitter

This block sends characters as asynchronous serial frames without a classic per-bit transmit state machine. Each character taken from a small holding queue is turned into one complete serial word in a single step. The character is moved up one position, masked to the configured data length, and combined with a stop-bit pattern, so that bit 0 of the word is the zero start bit. A plain synchronous serializer then clocks the word out least-significant bit first. A bit clock derived from a divisor sets how long each bit lasts.

The upstream logic writes bytes through a valid/ready port and controls the transmitter with three strobes. `cfg_load` takes a new data length, stop-bit count and divisor while the transmitter is stopped. `start` enables shifting. `drain` asks for a clean stop once the queue runs dry. After a reconfiguration the transmitter first sends two all-ones words so that the line settles at the idle level before real data. A write into a full queue, or a word boundary with nothing to send and no stop requested, is an error that halts transmission and forces the line high.

Top module: `pfu_tx_framer`

## Requirements
- R1: After reset `txd` is 1, `tx_active` is 0, `hold_empty` is 1, `fifo_full` is 0, `s_ready` is 1, and both error outputs are 0.
- R2: A frame on `txd` is a 0 start bit, then the data bits least-significant first, then stop bits at 1. Each bit lasts 2*(div+1) clock cycles, where div is the loaded divisor.
- R3: `cfg_len` selects the data length: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Character bits above that length are not sent.
- R4: With `cfg_two_stop` = 1 a frame carries two stop bits, and frame starts are (data length + 3) bit times apart. With 0 it carries one stop bit.
- R5: The queue holds DEPTH characters and sends them in write order. `fifo_full` is 1 exactly when DEPTH characters are held, and `s_ready` is its inverse.
- R6: A byte offered with `s_valid` while the queue is full is dropped. In the next cycle `err_ovf` is 1 for one cycle, `tx_active` is 0 and `txd` is 1.
- R7: If a word boundary is reached while shifting with an empty queue and no stop requested, `err_udf` pulses for one cycle, `tx_active` drops and `txd` stays 1. This includes a `start` with an empty queue, which gives the pulse one cycle after the enable is seen.
- R8: After `drain`, the transmitter sends everything queued. `tx_active` falls exactly when the final stop bit of the last character ends, with no underflow pulse, and the line rests at 1.
- R9: `cfg_load` while stopped applies the new settings, and the next `start` sends two all-ones words before the first character, so the first start bit appears 1 + 2*W*bit-time cycles after the cycle `start` is taken (W = data length + stop bits + 1). With no reconfiguration since reset, the first character starts one cycle after the enable. `cfg_load` while transmitting is ignored.
- R10: `hold_empty` is 1 exactly when the queue holds no character.
- R11: While characters remain queued, frames follow back to back: each start bit begins in the cycle the previous frame's last stop bit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Character offered |
| s_data | input | 8 | Character value |
| s_ready | output | 1 | Queue can take a character |
| cfg_load | input | 1 | Strobe: take the settings below (only while stopped) |
| cfg_len | input | 2 | Data length code, 0..3 for 5..8 bits |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_div | input | DIV_W | Bit-clock divisor; bit time is 2*(div+1) cycles |
| start | input | 1 | Strobe: enable transmission |
| drain | input | 1 | Strobe: stop cleanly once the queue is empty |
| txd | output | 1 | Serial line, idles high |
| tx_active | output | 1 | Transmit enable state |
| fifo_full | output | 1 | Queue has no free entry |
| hold_empty | output | 1 | Queue holds no character |
| err_ovf | output | 1 | One-cycle pulse: write into a full queue |
| err_udf | output | 1 | One-cycle pulse: word boundary with nothing to send |

## Verification
Two events can fall in the same cycle: a new character entering the queue and the serializer taking the head entry at a word boundary. The bench provokes this by timing a write so that it lands on the exact edge at which a frame's last stop bit ends. It then checks that every frame still emerges intact and in order, and that each starts exactly one word time after the previous one. Every other scenario sets up the queue level, the configuration and the strobes directly, and compares the sampled line against frames built from the requirements.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
  localparam int CHAR_W   = 8;
  localparam int WORD_MAX = CHAR_W + 3;
  localparam int LEN_W    = $clog2(WORD_MAX + 1);

  // Bits in one serial word: start + data + stop(s)
  function automatic logic [LEN_W-1:0] word_len(input logic [1:0] code, input logic two);
    return LEN_W'(7 + int'(code) + int'(two));
  endfunction

  // Shift the character up, keep the data field, then add the stop pattern
  function automatic logic [WORD_MAX-1:0] frame_word(input logic [CHAR_W-1:0] ch,
                                                     input logic [1:0] code,
                                                     input logic two);
    logic [WORD_MAX-1:0] dmask;
    logic [WORD_MAX-1:0] smask;
    logic [WORD_MAX-1:0] raw;
    int cs;
    cs    = 5 + int'(code);
    dmask = '0;
    for (int i = 1; i <= CHAR_W; i++) begin
      if (i <= cs) dmask[i] = 1'b1;
    end
    smask = '0;
    smask[cs+1] = 1'b1;
    if (two) smask[cs+2] = 1'b1;
    raw = {{(WORD_MAX-CHAR_W){1'b0}}, ch};
    return ((raw << 1) & dmask) | smask;
  endfunction
endpackage

// File: rtl/pfu_fifo.sv
module pfu_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt, cnt_nxt;

  // Storage without reset; combinational read keeps the head visible at a boundary
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end
  assign rdata = mem[rd_ptr];

  assign cnt_nxt = cnt + CW'(push) - CW'(pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      cnt   <= cnt_nxt;
      full  <= (cnt_nxt == CW'(DEPTH));
      empty <= (cnt_nxt == '0);
    end
  end

  a_r5_no_push_full: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/pfu_bitclk.sv
module pfu_bitclk #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W:0] cnt;
  logic [DIV_W:0] last;

  // Bit time 2*(div+1): the last count is 2*div+1
  assign last = {div, 1'b1};
  assign tick = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) cnt <= '0;
    else if (cnt == last)       cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
endmodule

// File: rtl/pfu_shifter.sv
module pfu_shifter
  import pfu_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                halt,
  input  logic                load,
  input  logic [WORD_MAX-1:0] word,
  input  logic [LEN_W-1:0]    len,
  input  logic                adv,
  output logic                txd,
  output logic                last,
  output logic                idle
);
  logic [WORD_MAX-1:0] sh;
  logic [LEN_W-1:0]    left;

  assign last = (left == LEN_W'(1));
  assign idle = (left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      left <= '0;
      txd  <= 1'b1;
    end else if (halt) begin
      sh   <= '1;
      left <= '0;
      txd  <= 1'b1;
    end else if (load) begin
      sh   <= word;
      left <= len;
      txd  <= word[0];
    end else if (adv) begin
      sh   <= {1'b1, sh[WORD_MAX-1:1]};
      left <= left - 1'b1;
      txd  <= sh[1];
    end
  end

  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (rst) idle |-> txd);
endmodule

// File: rtl/pfu_tx_framer.sv
module pfu_tx_framer
  import pfu_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int DIV_W    = 12,
  parameter int DIV_INIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  input  logic [CHAR_W-1:0] s_data,
  output logic              s_ready,
  input  logic              cfg_load,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_two_stop,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              start,
  input  logic              drain,
  output logic              txd,
  output logic              tx_active,
  output logic              fifo_full,
  output logic              hold_empty,
  output logic              err_ovf,
  output logic              err_udf
);
  localparam logic [1:0] PRIME_WORDS = 2'd2;

  logic              en_q, stop_q, two_q;
  logic [1:0]        prime_q, len_q;
  logic [DIV_W-1:0]  div_q;

  logic              f_full, f_empty, f_push, f_pop;
  logic [CHAR_W-1:0] f_rdata;
  logic              tick, sh_last, sh_idle;
  logic              ovf, bnd, ld_prime, ld_char, stop_ok, udf, adv, halt, ld;
  logic [WORD_MAX-1:0] ld_word;

  assign s_ready    = !f_full;
  assign fifo_full  = f_full;
  assign hold_empty = f_empty;
  assign tx_active  = en_q;

  assign ovf    = s_valid && f_full;
  assign f_push = s_valid && !f_full;

  // Word boundary: shifter idle, or last bit of the current word just ended
  assign bnd      = en_q && !ovf && (sh_idle || (tick && sh_last));
  assign ld_prime = bnd && (prime_q != 2'd0);
  assign ld_char  = bnd && (prime_q == 2'd0) && !f_empty;
  assign stop_ok  = bnd && (prime_q == 2'd0) && f_empty && stop_q;
  assign udf      = bnd && (prime_q == 2'd0) && f_empty && !stop_q;
  assign adv      = en_q && !ovf && tick && !sh_last && !sh_idle;
  assign halt     = ovf || stop_ok || udf;
  assign ld       = ld_prime || ld_char;
  assign f_pop    = ld_char;
  assign ld_word  = ld_prime ? '1 : frame_word(f_rdata, len_q, two_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      stop_q  <= 1'b0;
      prime_q <= 2'd0;
      len_q   <= 2'd3;
      two_q   <= 1'b0;
      div_q   <= DIV_W'(DIV_INIT);
      err_ovf <= 1'b0;
      err_udf <= 1'b0;
    end else begin
      err_ovf <= ovf;
      err_udf <= udf;
      if (halt)       en_q <= 1'b0;
      else if (start) en_q <= 1'b1;
      if (halt)              stop_q <= 1'b0;
      else if (drain && en_q) stop_q <= 1'b1;
      if (cfg_load && !en_q) begin
        len_q   <= cfg_len;
        two_q   <= cfg_two_stop;
        div_q   <= cfg_div;
        prime_q <= PRIME_WORDS;
      end else if (ld_prime) begin
        prime_q <= prime_q - 1'b1;
      end
    end
  end

  pfu_fifo #(.DW(CHAR_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(f_push), .wdata(s_data), .pop(f_pop),
    .rdata(f_rdata), .full(f_full), .empty(f_empty)
  );

  pfu_bitclk #(.DIV_W(DIV_W)) u_bitclk (
    .clk(clk), .rst(rst), .run(en_q), .restart(ld), .div(div_q), .tick(tick)
  );

  pfu_shifter u_shift (
    .clk(clk), .rst(rst), .halt(halt), .load(ld), .word(ld_word),
    .len(word_len(len_q, two_q)), .adv(adv), .txd(txd), .last(sh_last), .idle(sh_idle)
  );

  a_r6_overflow_halts: assert property (@(posedge clk) disable iff (rst)
    (s_valid && !s_ready) |=> (err_ovf && !tx_active && txd));
  a_r7_underflow_stops: assert property (@(posedge clk) disable iff (rst)
    err_udf |-> (!tx_active && txd));
  a_r9_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    en_q |=> ($stable(len_q) && $stable(two_q) && $stable(div_q)));
endmodule

// File: tb/tb_pfu_tx_framer.sv
module tb_pfu_tx_framer;
  localparam int DEPTH = 8;
  localparam int DIV_W = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic cfg_load = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_two_stop = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic start = 1'b0;
  logic drain = 1'b0;
  logic s_ready, txd, tx_active, fifo_full, hold_empty, err_ovf, err_udf;

  pfu_tx_framer #(.DEPTH(DEPTH), .DIV_W(DIV_W), .DIV_INIT(1)) dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .cfg_load(cfg_load), .cfg_len(cfg_len), .cfg_two_stop(cfg_two_stop), .cfg_div(cfg_div),
    .start(start), .drain(drain), .txd(txd), .tx_active(tx_active), .fifo_full(fifo_full),
    .hold_empty(hold_empty), .err_ovf(err_ovf), .err_udf(err_udf)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int udf_cnt = 0;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (err_udf) udf_cnt++;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; s_valid = 1'b0; cfg_load = 1'b0; start = 1'b0; drain = 1'b0;
    cfg_len = 2'd3; cfg_two_stop = 1'b0; cfg_div = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] code, input logic two, input int dv);
    @(negedge clk);
    cfg_len = code; cfg_two_stop = two; cfg_div = DIV_W'(dv); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    s_valid = 1'b1; s_data = b;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic go(output int c0);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c0 = cyc;
  endtask

  task automatic stop_req();
    @(negedge clk);
    drain = 1'b1;
    @(negedge clk);
    drain = 1'b0;
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Find the next start bit, then sample every bit at its middle
  task automatic capture(input logic [7:0] b, input int cs, input int ns, input int p,
                         input string rq, output int t0);
    logic [11:0] got, exp;
    int guard;
    guard = 0;
    @(negedge clk);
    while (txd !== 1'b0 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    t0 = cyc;
    got = '1;
    exp = '1;
    for (int k = 0; k < 1 + cs + ns; k++) begin
      wait_cyc(t0 + k * p + p / 2);
      got[k] = txd;
      exp[k] = (k == 0) ? 1'b0 : ((k <= cs) ? b[k-1] : 1'b1);
    end
    chk(got == exp, rq, int'(got), int'(exp));
  endtask

  task automatic t_reset();
    do_reset();
    chk(txd === 1'b1, "R1 txd", txd, 1);
    chk(tx_active === 1'b0, "R1 tx_active", tx_active, 0);
    chk(hold_empty === 1'b1 && fifo_full === 1'b0, "R1 queue flags", {hold_empty, fifo_full}, 2);
    chk(s_ready === 1'b1, "R1 s_ready", s_ready, 1);
    chk(err_ovf === 1'b0 && err_udf === 1'b0, "R1 errors", {err_ovf, err_udf}, 0);
  endtask

  task automatic t_fill_idle();
    int c0, t0, tx;
    do_reset();
    for (int i = 0; i < DEPTH - 1; i++) push(8'(8'h11 * (i + 1)));
    chk(fifo_full === 1'b0, "R5 not full at DEPTH-1", fifo_full, 0);
    chk(hold_empty === 1'b0, "R10 holding", hold_empty, 0);
    push(8'h88);
    chk(fifo_full === 1'b1 && s_ready === 1'b0, "R5 full at DEPTH", {fifo_full, s_ready}, 2);
    push(8'hEE);
    chk(err_ovf === 1'b1, "R6 overflow pulse", err_ovf, 1);
    go(c0);
    capture(8'h11, 8, 1, 4, "R5 first", t0);
    chk(t0 == c0 + 1, "R9 no priming after reset", t0 - c0, 1);
    for (int i = 1; i < DEPTH; i++) capture(8'(8'h11 * (i + 1)), 8, 1, 4, "R5 order", tx);
    chk(hold_empty === 1'b1, "R10 empty after sending", hold_empty, 1);
  endtask

  task automatic t_underflow();
    int c0;
    do_reset();
    go(c0);
    chk(tx_active === 1'b1, "R7 enabled", tx_active, 1);
    @(negedge clk);
    chk(err_udf === 1'b1 && tx_active === 1'b0 && txd === 1'b1, "R7 underflow",
        {err_udf, tx_active, txd}, 5);
    @(negedge clk);
    chk(err_udf === 1'b0, "R7 single pulse", err_udf, 0);
  endtask

  task automatic t_prime_short();
    int c0, t0, base;
    do_reset();
    set_cfg(2'd0, 1'b0, 1);
    push(8'hE6);
    base = udf_cnt;
    go(c0);
    stop_req();
    capture(8'hE6, 5, 1, 4, "R3 five bits", t0);
    chk(t0 - c0 == 1 + 2 * 7 * 4, "R9 two idle words", t0 - c0, 57);
    wait_cyc(t0 + 27);
    chk(tx_active === 1'b1, "R8 active to last stop", tx_active, 1);
    wait_cyc(t0 + 28);
    chk(tx_active === 1'b0 && txd === 1'b1, "R8 clean stop", {tx_active, txd}, 1);
    chk(udf_cnt == base, "R8 no underflow", udf_cnt - base, 0);
  endtask

  task automatic t_len_stop();
    int c0, ta, tb;
    do_reset();
    set_cfg(2'd2, 1'b1, 3);
    push(8'h3B);
    push(8'hC4);
    go(c0);
    stop_req();
    capture(8'h3B, 7, 2, 8, "R4 seven bits two stops", ta);
    capture(8'hC4, 7, 2, 8, "R4 second frame", tb);
    chk(tb - ta == 80, "R4 R2 word time", tb - ta, 80);
    do_reset();
    set_cfg(2'd1, 1'b0, 2);
    push(8'h95);
    go(c0);
    stop_req();
    capture(8'h95, 6, 1, 6, "R3 six bits", ta);
  endtask

  task automatic t_stream();
    int c0, base;
    int t [4];
    do_reset();
    set_cfg(2'd3, 1'b0, 1);
    push(8'h5A);
    push(8'hC3);
    push(8'h0F);
    base = udf_cnt;
    go(c0);
    stop_req();
    fork
      begin
        capture(8'h5A, 8, 1, 4, "R11 frame A", t[0]);
        capture(8'hC3, 8, 1, 4, "R11 frame B", t[1]);
        capture(8'h0F, 8, 1, 4, "R11 frame C", t[2]);
        capture(8'hA5, 8, 1, 4, "R9 frame D ignores cfg", t[3]);
      end
      begin
        int ta;
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        ta = cyc;
        wait_cyc(ta + 39);
        s_valid = 1'b1; s_data = 8'hA5;
        @(negedge clk);
        s_valid = 1'b0;
        wait_cyc(ta + 60);
        cfg_len = 2'd0; cfg_two_stop = 1'b1; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
      end
    join
    chk(t[1] - t[0] == 40, "R11 gap A-B", t[1] - t[0], 40);
    chk(t[2] - t[1] == 40, "R11 gap B-C", t[2] - t[1], 40);
    chk(t[3] - t[2] == 40, "R11 gap C-D", t[3] - t[2], 40);
    wait_cyc(t[3] + 39);
    chk(tx_active === 1'b1, "R8 still active", tx_active, 1);
    wait_cyc(t[3] + 40);
    chk(tx_active === 1'b0 && txd === 1'b1, "R8 stop after D", {tx_active, txd}, 1);
    chk(udf_cnt == base, "R8 no underflow stream", udf_cnt - base, 0);
  endtask

  task automatic t_ovf_active();
    int c0;
    do_reset();
    push(8'h61);
    go(c0);
    for (int i = 0; i < DEPTH; i++) push(8'(8'h70 + i));
    chk(fifo_full === 1'b1 && tx_active === 1'b1, "R5 full while sending", {fifo_full, tx_active}, 3);
    push(8'h99);
    chk(err_ovf === 1'b1 && tx_active === 1'b0 && txd === 1'b1, "R6 overflow halts",
        {err_ovf, tx_active, txd}, 5);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    t_reset();
    t_fill_idle();
    t_underflow();
    t_prime_short();
    t_len_stop();
    t_stream();
    t_ovf_active();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end
endmodule